// File: doc/BRIEF.md
# Segmented Page-Table Miss Walker

This block resolves a virtual address into a page descriptor after the page descriptor cache has missed. On a start pulse it takes the virtual address, the kind of access, the per-section table bases and lengths, and the current lookup result of the segment descriptor cache. It first checks the segment index against the length of the addressed section. It then obtains the two-word segment descriptor, from the cache or from memory, and follows indirect descriptors up to a hop limit. Next it checks presence and length. It then either builds the page descriptor for a contiguous segment or fetches it from the page table. Finally it checks write protection and page presence.

The walker has one word-read memory port with at most one read in flight. It ends every walk with a one-cycle `done` strobe that carries a 4-bit fault code. On success it also gives the page descriptor, the final segment descriptor, and write strobes for the surrounding caches. Cache storage and history-bit write-back are left to neighbouring blocks.

Virtual address layout: bits 31:30 select the section, bits 29:17 are the segment index, bits 16:11 are the page index and bits 10:0 are the byte offset (2 KiB pages). Segment descriptor control word: bit 0 present, bit 2 contiguous, bit 6 valid, bit 7 indirect, bits 25:24 permission, bit 23 referenced, bit 22 modified, bits 20:10 maximum segment offset (bits 20:15 alone give the last page of a contiguous segment). Page descriptor: bit 0 present, bit 1 modified, bit 4 write-protect, bit 5 referenced, bits 31:11 frame. Access codes: 0 read, 1 write, 2 instruction fetch, 3 fetch after discontinuity. Permission codes: 0 nothing, 1 fetch-after-discontinuity only, 2 read or fetch-after-discontinuity, 3 everything.

Top module: `segWalker`

## Requirements
- R1: When start arrives, the walker takes the section from va[31:30]. If va[29:17] is greater than that section's length, the walk ends with fault 1 and reads no memory.
- R2: If sdcHit is set at start, the walker uses sdcCtl/sdcAddr and does no descriptor read. Otherwise it reads the control word at base + index×8 and the address word at base + index×8 + 4. On success sdWr is 1 only when the descriptor came from memory, and pdWr is always 1.
- R3: A descriptor whose valid bit (bit 6) is clear ends the walk with fault 2.
- R4: An indirect descriptor (bit 7) makes the walker read the next descriptor pair at the address in its second word. The hop that would exceed MAX_HOPS (default 3) ends the walk with fault 3.
- R5: An indirect descriptor whose permission rejects the access ends the walk with fault 4.
- R6: A valid descriptor whose present bit is clear gives fault 5 when it is contiguous and fault 6 when it is paged.
- R7: A contiguous segment faults with 7 when va[16:11] > ctl[20:15]. A paged segment faults with 8 when va[16:0] > {ctl[20:10], 6'h3f}.
- R8: For a contiguous segment a failed permission check gives fault 9. Otherwise the page descriptor is ((addr & ~0x7ff) + va[16:11]×2048), with ctl[23] in bit 5, ctl[22] in bit 1, and bit 0 set.
- R9: For a paged segment the page descriptor is the word read at addr + va[16:11]×4.
- R10: A write to a page descriptor with bit 4 set gives fault 10. A page descriptor with bit 0 clear gives fault 11. A successful walk returns a present descriptor.
- R11: An instruction fetch (code 2) is treated as a fetch after discontinuity (code 3) in every permission check.
- R12: No new read request is issued while a read is outstanding. `done` is a one-cycle pulse. A faulted walk raises neither write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (only while idle) |
| va | input | 32 | Virtual address |
| accKind | input | 2 | Access kind code |
| secBaseTbl | input | SECTIONS×32 | Segment table base per section |
| secLenTbl | input | SECTIONS×13 | Last valid segment index per section |
| sdcHit | input | 1 | Segment descriptor cache hit |
| sdcCtl | input | 32 | Cached control word |
| sdcAddr | input | 32 | Cached address word |
| memReq | output | 1 | Word read request (one cycle) |
| memAddr | output | 32 | Read address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 4 | Fault code, 0 on success |
| pdOut | output | 32 | Resulting page descriptor |
| sdCtlOut | output | 32 | Final segment descriptor control word |
| sdAddrOut | output | 32 | Final segment descriptor address word |
| sdWr | output | 1 | Write segment descriptor into its cache |
| pdWr | output | 1 | Write page descriptor into its cache |

## Verification
The checker watches a few properties on every cycle. It checks the single outstanding read, the one-cycle `done` pulse, that a faulted walk never raises a cache write, that `sdWr` never comes without `pdWr`, and that a good result is always a present descriptor. The order in which faults win, the addresses read, the number of indirect hops, the reclassified fetch and the synthesised contiguous descriptor depend on descriptor contents. Only the bench's scenarios can show them, and each one is compared against a model walk over the bench memory.

// File: rtl/segWalkerPkg.sv
package segWalkerPkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 13;

  localparam logic [1:0] ACC_READ    = 2'd0;
  localparam logic [1:0] ACC_WRITE   = 2'd1;
  localparam logic [1:0] ACC_FETCH   = 2'd2;
  localparam logic [1:0] ACC_FETCHAD = 2'd3;

  localparam logic [3:0] FLT_NONE    = 4'd0;
  localparam logic [3:0] FLT_TBLLEN  = 4'd1;
  localparam logic [3:0] FLT_BADSD   = 4'd2;
  localparam logic [3:0] FLT_HOPS    = 4'd3;
  localparam logic [3:0] FLT_MISSMEM = 4'd4;
  localparam logic [3:0] FLT_SEGNP   = 4'd5;
  localparam logic [3:0] FLT_PDTNP   = 4'd6;
  localparam logic [3:0] FLT_SEGOFF  = 4'd7;
  localparam logic [3:0] FLT_PDTLEN  = 4'd8;
  localparam logic [3:0] FLT_ACCESS  = 4'd9;
  localparam logic [3:0] FLT_PGWRITE = 4'd10;
  localparam logic [3:0] FLT_PGNP    = 4'd11;

  typedef struct packed {
    logic capture;
    logic takeCache;
    logic loadCtl;
    logic loadAddr;
    logic hop;
    logic pdtPtr;
    logic loadPd;
    logic buildPd;
    logic hiSel;
    logic finish;
  } strobeT;

  typedef struct packed {
    logic segTooBig;
    logic sdValid;
    logic sdIndirect;
    logic sdPresent;
    logic sdContig;
    logic hopsFull;
    logic permOk;
    logic pageOver;
    logic offOver;
    logic isWrite;
    logic pdWp;
    logic pdPresent;
  } statusT;

  function automatic logic permits(logic [1:0] perm, logic [1:0] acc);
    case (perm)
      2'd0:    permits = 1'b0;
      2'd1:    permits = (acc == ACC_FETCHAD);
      2'd2:    permits = (acc == ACC_READ) || (acc == ACC_FETCHAD);
      default: permits = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/segWalkerDp.sv
module segWalkerDp
  import segWalkerPkg::*;
#(
  parameter int MAX_HOPS = 3,
  parameter int SECTIONS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [WORD_W-1:0]              va,
  input  logic [1:0]                     accKind,
  input  logic [SECTIONS-1:0][WORD_W-1:0] secBaseTbl,
  input  logic [SECTIONS-1:0][IDX_W-1:0]  secLenTbl,
  input  logic [WORD_W-1:0]              sdcCtl,
  input  logic [WORD_W-1:0]              sdcAddr,
  input  logic [WORD_W-1:0]              memData,
  input  strobeT                         sb,
  input  logic [3:0]                     faultCode,
  output statusT                         st,
  output logic [WORD_W-1:0]              memAddr,
  output logic                           done,
  output logic [3:0]                     fault,
  output logic [WORD_W-1:0]              pdOut,
  output logic [WORD_W-1:0]              sdCtlOut,
  output logic [WORD_W-1:0]              sdAddrOut,
  output logic                           sdWr,
  output logic                           pdWr
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);
  localparam int SEC_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1;

  logic [16:0]       vaQ;
  logic [1:0]        accQ;
  logic [WORD_W-1:0] ptrQ, ctlQ, addrQ, pdQ;
  logic [HOP_W-1:0]  hopQ;
  logic              fromMemQ;

  logic [SEC_W-1:0]  secSel;
  logic [IDX_W-1:0]  segIdx;
  logic [5:0]        pageIdx;

  assign secSel  = SEC_W'(va[31:30]);
  assign segIdx  = va[29:17];
  assign pageIdx = vaQ[16:11];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; accQ <= ACC_READ; ptrQ <= '0; ctlQ <= '0; addrQ <= '0;
      pdQ <= '0; hopQ <= '0; fromMemQ <= 1'b0;
    end else begin
      if (sb.capture) begin
        vaQ      <= va[16:0];
        accQ     <= (accKind == ACC_FETCH) ? ACC_FETCHAD : accKind;
        ptrQ     <= secBaseTbl[secSel] + WORD_W'({segIdx, 3'b000});
        hopQ     <= '0;
        fromMemQ <= 1'b1;
      end
      if (sb.takeCache) begin
        ctlQ     <= sdcCtl;
        addrQ    <= sdcAddr;
        fromMemQ <= 1'b0;
      end
      if (sb.loadCtl)  ctlQ  <= memData;
      if (sb.loadAddr) addrQ <= memData;
      if (sb.hop) begin
        hopQ <= hopQ + HOP_W'(1);
        ptrQ <= addrQ;
      end
      if (sb.pdtPtr)  ptrQ <= addrQ + WORD_W'({pageIdx, 2'b00});
      if (sb.loadPd)  pdQ  <= memData;
      if (sb.buildPd)
        pdQ <= ((addrQ & 32'hFFFF_F800) + WORD_W'({pageIdx, 11'b0}))
             | {26'b0, ctlQ[23], 3'b000, ctlQ[22], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; fault <= FLT_NONE; pdOut <= '0; sdCtlOut <= '0;
      sdAddrOut <= '0; sdWr <= 1'b0; pdWr <= 1'b0;
    end else begin
      done <= sb.finish;
      sdWr <= sb.finish && (faultCode == FLT_NONE) && fromMemQ;
      pdWr <= sb.finish && (faultCode == FLT_NONE);
      if (sb.finish) begin
        fault     <= faultCode;
        pdOut     <= pdQ;
        sdCtlOut  <= ctlQ;
        sdAddrOut <= addrQ;
      end
    end
  end

  assign memAddr = ptrQ + (sb.hiSel ? WORD_W'(4) : WORD_W'(0));

  always_comb begin
    st.segTooBig  = segIdx > secLenTbl[secSel];
    st.sdValid    = ctlQ[6];
    st.sdIndirect = ctlQ[7];
    st.sdPresent  = ctlQ[0];
    st.sdContig   = ctlQ[2];
    st.hopsFull   = (hopQ == HOP_W'(MAX_HOPS));
    st.permOk     = permits(ctlQ[25:24], accQ);
    st.pageOver   = pageIdx > ctlQ[20:15];
    st.offOver    = vaQ > {ctlQ[20:10], 6'h3f};
    st.isWrite    = (accQ == ACC_WRITE);
    st.pdWp       = pdQ[4];
    st.pdPresent  = pdQ[0];
  end
endmodule

// File: rtl/segWalkerCtl.sv
module segWalkerCtl
  import segWalkerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       sdcHit,
  input  logic       memValid,
  input  statusT     st,
  output strobeT     sb,
  output logic [3:0] faultCode,
  output logic       memReq
);
  typedef enum logic [3:0] {
    S_IDLE, S_RDLO, S_WTLO, S_RDHI, S_WTHI, S_SDCHK, S_RDPD, S_WTPD, S_PDCHK
  } stateT;

  stateT state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign memReq = (state == S_RDLO) || (state == S_RDHI) || (state == S_RDPD);

  always_comb begin
    sb        = '0;
    faultCode = FLT_NONE;
    nxt       = state;
    case (state)
      S_IDLE: if (start) begin
        sb.capture = 1'b1;
        if (st.segTooBig)  faultCode = FLT_TBLLEN;
        else if (sdcHit) begin sb.takeCache = 1'b1; nxt = S_SDCHK; end
        else               nxt = S_RDLO;
      end
      S_RDLO: nxt = S_WTLO;
      S_WTLO: if (memValid) begin sb.loadCtl = 1'b1; nxt = S_RDHI; end
      S_RDHI: begin sb.hiSel = 1'b1; nxt = S_WTHI; end
      S_WTHI: if (memValid) begin sb.loadAddr = 1'b1; nxt = S_SDCHK; end
      S_SDCHK: begin
        if (!st.sdValid) faultCode = FLT_BADSD;
        else if (st.sdIndirect) begin
          if (st.hopsFull)     faultCode = FLT_HOPS;
          else if (!st.permOk) faultCode = FLT_MISSMEM;
          else begin sb.hop = 1'b1; nxt = S_RDLO; end
        end
        else if (!st.sdPresent) faultCode = st.sdContig ? FLT_SEGNP : FLT_PDTNP;
        else if (st.sdContig) begin
          if (st.pageOver)     faultCode = FLT_SEGOFF;
          else if (!st.permOk) faultCode = FLT_ACCESS;
          else begin sb.buildPd = 1'b1; nxt = S_PDCHK; end
        end
        else if (st.offOver) faultCode = FLT_PDTLEN;
        else begin sb.pdtPtr = 1'b1; nxt = S_RDPD; end
      end
      S_RDPD: nxt = S_WTPD;
      S_WTPD: if (memValid) begin sb.loadPd = 1'b1; nxt = S_PDCHK; end
      S_PDCHK: begin
        if (st.isWrite && st.pdWp) faultCode = FLT_PGWRITE;
        else if (!st.pdPresent)    faultCode = FLT_PGNP;
        else begin sb.finish = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
    if (faultCode != FLT_NONE) begin
      sb.finish = 1'b1;
      nxt       = S_IDLE;
    end
  end
endmodule

// File: rtl/segWalker.sv
module segWalker
  import segWalkerPkg::*;
#(
  parameter int MAX_HOPS = 3,
  parameter int SECTIONS = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            start,
  input  logic [31:0]                     va,
  input  logic [1:0]                      accKind,
  input  logic [SECTIONS-1:0][31:0]       secBaseTbl,
  input  logic [SECTIONS-1:0][12:0]       secLenTbl,
  input  logic                            sdcHit,
  input  logic [31:0]                     sdcCtl,
  input  logic [31:0]                     sdcAddr,
  output logic                            memReq,
  output logic [31:0]                     memAddr,
  input  logic                            memValid,
  input  logic [31:0]                     memData,
  output logic                            done,
  output logic [3:0]                      fault,
  output logic [31:0]                     pdOut,
  output logic [31:0]                     sdCtlOut,
  output logic [31:0]                     sdAddrOut,
  output logic                            sdWr,
  output logic                            pdWr
);
  strobeT     sb;
  statusT     st;
  logic [3:0] faultCode;

  segWalkerCtl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .sdcHit(sdcHit), .memValid(memValid),
    .st(st), .sb(sb), .faultCode(faultCode), .memReq(memReq)
  );

  segWalkerDp #(.MAX_HOPS(MAX_HOPS), .SECTIONS(SECTIONS)) u_dp (
    .clk(clk), .rstN(rstN), .va(va), .accKind(accKind),
    .secBaseTbl(secBaseTbl), .secLenTbl(secLenTbl),
    .sdcCtl(sdcCtl), .sdcAddr(sdcAddr), .memData(memData),
    .sb(sb), .faultCode(faultCode), .st(st), .memAddr(memAddr),
    .done(done), .fault(fault), .pdOut(pdOut), .sdCtlOut(sdCtlOut),
    .sdAddrOut(sdAddrOut), .sdWr(sdWr), .pdWr(pdWr)
  );
endmodule

// File: rtl/segWalkerChk.sv
module segWalkerChk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memValid,
  input logic        done,
  input logic [3:0]  fault,
  input logic [31:0] pdOut,
  input logic        sdWr,
  input logic        pdWr
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN)         outstanding <= 1'b0;
    else if (memReq)   outstanding <= 1'b1;
    else if (memValid) outstanding <= 1'b0;
  end

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !outstanding);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  fault_nofill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault != 4'd0) |-> (!pdWr && !sdWr));

  // R2
  sd_with_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdWr |-> (pdWr && done));

  // R10
  ok_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault == 4'd0) |-> pdOut[0]);
endmodule

bind segWalker segWalkerChk u_chk (.*);

// File: tb/segWalker_bench.sv
module segWalker_bench;
  localparam int MAX_HOPS = 3;
  localparam logic [31:0] BV = 32'h40, BI = 32'h80, BP = 32'h1, BC = 32'h4;
  localparam logic [31:0] PERM3 = 32'h0300_0000, PERM1 = 32'h0100_0000;
  localparam logic [31:0] BR = 32'h0080_0000, BM = 32'h0040_0000;
  localparam logic [31:0] MAXALL = 32'h001F_FC00;

  logic clk = 0, rstN = 0, start = 0, sdcHit = 0, memValid = 0;
  logic [31:0] va = 0, sdcCtl = 0, sdcAddr = 0, memData = 0;
  logic [1:0]  accKind = 0;
  logic [3:0][31:0] secBaseTbl;
  logic [3:0][12:0] secLenTbl;
  logic memReq, done, sdWr, pdWr;
  logic [31:0] memAddr, pdOut, sdCtlOut, sdAddrOut;
  logic [3:0] fault;

  always #5 clk = ~clk;

  segWalker #(.MAX_HOPS(MAX_HOPS), .SECTIONS(4)) u_segWalker (.*);

  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder: answers each request two cycles later
  logic [31:0] pendAddr = 0;
  int lat = 0, readCnt = 0;
  always @(posedge clk) begin
    memValid <= 1'b0;
    if (memReq) begin
      pendAddr <= memAddr; lat <= 2; readCnt <= readCnt + 1;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin memValid <= 1'b1; memData <= rd(pendAddr); end
    end
  end

  typedef struct {
    logic [3:0] flt; logic [31:0] pd, sctl, saddr; logic sw, pw;
    int reads, base; string tag;
  } itemT;
  itemT q[$];
  int errors = 0, checks = 0;
  bit finished = 0;

  function automatic logic permOk(logic [1:0] p, logic [1:0] a);
    case (p)
      2'd0: return 1'b0;
      2'd1: return a == 2'd3;
      2'd2: return a == 2'd0 || a == 2'd3;
      default: return 1'b1;
    endcase
  endfunction

  function automatic itemT model(logic [31:0] v, logic [1:0] acc, logic hit,
                                 logic [31:0] cc, logic [31:0] ca);
    itemT it; logic [31:0] ctl, adr, ptr, pd; logic fromMem; int hops;
    logic [1:0] a;
    logic [5:0] pg;
    it.flt = 0; it.pd = 0; it.sw = 0; it.pw = 0; it.reads = 0;
    it.sctl = 0; it.saddr = 0; it.base = 0; it.tag = "";
    a = (acc == 2'd2) ? 2'd3 : acc;
    pg = v[16:11];
    if (v[29:17] > secLenTbl[v[31:30]]) begin it.flt = 1; return it; end
    ptr = secBaseTbl[v[31:30]] + {16'b0, v[29:17], 3'b0};
    if (hit) begin ctl = cc; adr = ca; fromMem = 0; end
    else begin ctl = rd(ptr); adr = rd(ptr + 4); it.reads = 2; fromMem = 1; end
    hops = 0;
    for (int k = 0; k < 16; k++) begin
      if (!ctl[6]) begin it.flt = 2; return it; end
      if (!ctl[7]) break;
      if (hops + 1 > MAX_HOPS) begin it.flt = 3; return it; end
      if (!permOk(ctl[25:24], a)) begin it.flt = 4; return it; end
      hops++; ptr = adr; ctl = rd(ptr); adr = rd(ptr + 4); it.reads += 2;
    end
    if (!ctl[0]) begin it.flt = ctl[2] ? 4'd5 : 4'd6; return it; end
    if (ctl[2]) begin
      if (pg > ctl[20:15]) begin it.flt = 7; return it; end
      if (!permOk(ctl[25:24], a)) begin it.flt = 9; return it; end
      pd = ((adr & 32'hFFFF_F800) + ({26'b0, pg} << 11)) | (ctl[23] ? 32'h20 : 0)
           | (ctl[22] ? 32'h2 : 0) | 32'h1;
    end else begin
      if (v[16:0] > {ctl[20:10], 6'h3f}) begin it.flt = 8; return it; end
      pd = rd(adr + {24'b0, pg, 2'b0}); it.reads += 1;
    end
    if (acc == 2'd1 && pd[4]) begin it.flt = 10; return it; end
    if (!pd[0]) begin it.flt = 11; return it; end
    it.pd = pd; it.pw = 1; it.sw = fromMem; it.sctl = ctl; it.saddr = adr;
    return it;
  endfunction

  function automatic logic [31:0] mkVa(int s, int idx, int pg, int off);
    return {s[1:0], idx[12:0], pg[5:0], off[10:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // driver: pushes expected result then runs one walk
  task automatic runCase(string tag, logic [31:0] v, logic [1:0] acc, logic hit = 0,
                         logic [31:0] cc = 0, logic [31:0] ca = 0);
    itemT it;
    it = model(v, acc, hit, cc, ca);
    it.tag = tag; it.base = readCnt;
    q.push_back(it);
    @(negedge clk);
    va = v; accKind = acc; sdcHit = hit; sdcCtl = cc; sdcAddr = ca; start = 1;
    @(negedge clk);
    start = 0; sdcHit = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each finished walk with the queue head
  always @(negedge clk) begin
    if (rstN && done) begin
      itemT e;
      if (q.size() == 0) check(0, "R12", "unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        check(fault == e.flt, e.tag, "fault", {28'b0, fault}, {28'b0, e.flt});
        check(readCnt - e.base == e.reads, e.tag, "reads", readCnt - e.base, e.reads);
        check(sdWr == e.sw && pdWr == e.pw, e.tag, "fill", {30'b0, sdWr, pdWr}, {30'b0, e.sw, e.pw});
        if (e.flt == 0) begin
          check(pdOut == e.pd, e.tag, "pd", pdOut, e.pd);
          check(sdCtlOut == e.sctl && sdAddrOut == e.saddr, e.tag, "sd", sdAddrOut, e.saddr);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    secBaseTbl[0] = 32'h1000; secLenTbl[0] = 13'd4;
    secBaseTbl[1] = 32'h2000; secLenTbl[1] = 13'd0;
    secBaseTbl[2] = 32'h3000; secLenTbl[2] = 13'd0;
    secBaseTbl[3] = 32'h3000; secLenTbl[3] = 13'd0;
    mem[32'h1000] = BV | BP | PERM3 | MAXALL; mem[32'h1004] = 32'h4000;
    mem[32'h400C] = 32'h00AB_C801; mem[32'h4010] = 32'h00AB_D811; mem[32'h4014] = 0;
    mem[32'h1008] = 0;
    mem[32'h1010] = BV | BC; mem[32'h1014] = 32'h50000;
    mem[32'h1018] = BV;      mem[32'h101C] = 32'h60000;
    mem[32'h1020] = BV | BP | BC | PERM3 | BR | BM | (32'd7 << 15); mem[32'h1024] = 32'h0022_0000;
    mem[32'h2000] = BV | BP | BC | PERM3 | (32'd3 << 15); mem[32'h2004] = 32'h0033_0000;
    mem[32'h8000] = BV | BI | PERM3; mem[32'h8004] = 32'h8010;
    mem[32'h8010] = BV | BP | BC | PERM3 | (32'd63 << 15); mem[32'h8014] = 32'h0044_0000;
    mem[32'h9000] = BV | BI | PERM3; mem[32'h9004] = 32'h9010;
    mem[32'h9010] = BV | BI | PERM3; mem[32'h9014] = 32'h9020;
    mem[32'h9020] = BV | BI | PERM3; mem[32'h9024] = 32'h9030;

    repeat (3) @(negedge clk);
    check(done == 0 && memReq == 0, "R12", "reset done/memReq", {30'b0, done, memReq}, 0);
    check(pdWr == 0 && sdWr == 0 && fault == 0, "R12", "reset outputs", {26'b0, fault, pdWr, sdWr}, 0);
    rstN = 1;

    runCase("R1 index over length", mkVa(0, 5, 0, 0), 2'd0);
    runCase("R1 section one length", mkVa(1, 1, 0, 0), 2'd0);
    runCase("R1 section one select", mkVa(1, 0, 2, 4), 2'd0);
    runCase("R9 paged read", mkVa(0, 0, 3, 16), 2'd0);
    runCase("R2 cache hit", mkVa(0, 0, 3, 16), 2'd0, 1, BV | BP | PERM3 | MAXALL, 32'h4000);
    runCase("R10 write protect", mkVa(0, 0, 4, 0), 2'd1);
    runCase("R10 read protected page", mkVa(0, 0, 4, 0), 2'd0);
    runCase("R10 page absent", mkVa(0, 0, 5, 0), 2'd0);
    runCase("R3 invalid", mkVa(0, 1, 0, 0), 2'd0);
    runCase("R6 contig absent", mkVa(0, 2, 0, 0), 2'd0);
    runCase("R6 paged absent", mkVa(0, 3, 0, 0), 2'd0);
    runCase("R8 contig build", mkVa(0, 4, 5, 12'h123), 2'd0);
    runCase("R8 contig write", mkVa(0, 4, 7, 0), 2'd1);
    runCase("R7 contig length", mkVa(0, 4, 8, 0), 2'd0);
    runCase("R7 paged length", mkVa(0, 0, 0, 12'h40), 2'd0, 1, BV | BP | PERM3, 32'h4000);
    runCase("R7 paged at limit", mkVa(0, 0, 0, 12'h3f), 2'd0, 1, BV | BP | PERM3, 32'h4000);
    runCase("R8 contig perm read", mkVa(0, 0, 1, 0), 2'd0, 1, BV | BP | BC | PERM1 | (32'd7 << 15), 32'h0055_0000);
    runCase("R11 fetch reclassified", mkVa(0, 0, 1, 0), 2'd2, 1, BV | BP | BC | PERM1 | (32'd7 << 15), 32'h0055_0000);
    runCase("R11 fetch after discontinuity", mkVa(0, 0, 2, 0), 2'd3, 1, BV | BP | BC | PERM1 | (32'd7 << 15), 32'h0055_0000);
    runCase("R4 indirect chain", mkVa(0, 0, 2, 0), 2'd0, 1, BV | BI | PERM3, 32'h8000);
    runCase("R4 hop limit", mkVa(0, 0, 0, 0), 2'd0, 1, BV | BI | PERM3, 32'h9000);
    runCase("R5 indirect perm", mkVa(0, 0, 0, 0), 2'd0, 1, BV | BI, 32'h8000);
    runCase("R5 R11 indirect fetch", mkVa(0, 0, 3, 0), 2'd2, 1, BV | BI | PERM1, 32'h8000);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R12", "all walks done", q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule